// File: doc/BRIEF.md
# Interrupt Status Summary with Alert

This block gathers seven event sources into one 8-bit summary status word and drives an active-low alert line. Each status bit is sticky: a single-cycle event pulse sets it, and it holds until its own clearing rule fires. The sources are a die over-temperature trip, a critical-temperature group, a general-purpose input group, a fan group, a high-limit group, a low-limit group and a sensor-fault group.

Bits clear in one of two ways. The over-temperature and general-purpose input bits clear when the host reads the word, but only if their event is absent in the read cycle. The five group bits ignore reads. They follow their sub-status registers instead, and clear when that group reports it has been cleared. An event in the same cycle as any clear always wins. The alert line goes low while any enabled group bit, other than the over-temperature bit, is set. It is released once none remains.

Top module: `intr_summary_status`

## Requirements
- R1: After a synchronous reset, `rd_data` is 8'h00 and `alert_n` is 1.
- R2: Bit positions in `ev`, `grp_clr` and `rd_data` are: 6 die over-temperature, 5 critical, 4 general-purpose input, 3 fan, 2 high, 1 low, 0 fault. `rd_data[7]` always reads 0.
- R3: A one-cycle pulse on `ev[i]` sets `rd_data[i]` at the next clock edge. The bit then stays set while no clear rule applies.
- R4: For bits 6 and 4, a cycle with `rd_stb` high clears the bit at the next edge if `ev` for that bit is low in that cycle. If `ev` is high in that cycle, the bit stays set.
- R5: For bits 5, 3, 2, 1 and 0, `rd_stb` has no effect. `grp_clr[i]` high clears the bit at the next edge unless `ev[i]` is high in the same cycle, in which case the bit stays set.
- R6: `grp_clr[6]` and `grp_clr[4]` have no effect on the status.
- R7: In a cycle with `rd_stb` high, `rd_data` shows the status value before the clear-on-read update.
- R8: `alert_n` is 0 exactly when some bit i in 0..5 of the status is set with `alert_en[i]` = 1. `alert_en` uses the same bit positions as the status. The line follows status and enables within the same cycle.
- R9: The over-temperature bit (bit 6) never changes `alert_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle host read strobe for the summary word |
| ev | input | 7 | Event pulses per status bit |
| grp_clr | input | 7 | Sub-status group cleared indications per bit |
| alert_en | input | 6 | Per-bit alert enable for bits 5..0 |
| rd_data | output | 8 | Summary status read data |
| alert_n | output | 1 | Active-low alert |

## Verification
The assertions check on every cycle that the reserved bit stays 0, that events set bits, that the read-clear bits drop after a quiet read, that group bits survive reads, and that the alert line agrees with the status and enables. Some behaviour only the bench scenarios can show. These cases are the race between an event and a clear in the same cycle, the pre-update value on a read, and that group clears are ignored on the read-cleared bits. The bench also sweeps every event pattern against every enable pattern.

// File: rtl/isa_pkg.sv
package isa_pkg;
    localparam int STAT_W    = 8;
    localparam int SRC_W     = STAT_W - 1;
    localparam int ALERT_SRC = 6;
    localparam int BIT_OVT   = 6;
    localparam int BIT_GPI   = 4;

    typedef enum logic {
        CLR_BY_READ  = 1'b0,
        CLR_BY_GROUP = 1'b1
    } clr_mode_e;

    typedef struct packed {
        logic set;
        logic rd;
        logic grp;
    } bit_ctl_t;

    function automatic clr_mode_e mode_of(input int idx);
        return (idx == BIT_OVT || idx == BIT_GPI) ? CLR_BY_READ : CLR_BY_GROUP;
    endfunction
endpackage

// File: rtl/isa_status_cell.sv
module isa_status_cell
    import isa_pkg::*;
#(
    parameter clr_mode_e MODE = CLR_BY_GROUP
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_ctl_t ctl,
    output logic     q
);
    logic clr_req;

    // The mode picks which clear source applies; the event always wins.
    assign clr_req = (MODE == CLR_BY_READ) ? ctl.rd : ctl.grp;

    always_ff @(posedge clk) begin
        if (rst)            q <= 1'b0;
        else if (ctl.set)   q <= 1'b1;
        else if (clr_req)   q <= 1'b0;
    end
endmodule

// File: rtl/isa_status_bank.sv
module isa_status_bank
    import isa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic [SRC_W-1:0]  ev,
    input  logic [SRC_W-1:0]  grp_clr,
    output logic [STAT_W-1:0] status
);
    genvar i;
    generate
        for (i = 0; i < SRC_W; i++) begin : g_bit
            bit_ctl_t ctl;
            assign ctl = '{set: ev[i], rd: rd_stb, grp: grp_clr[i]};
            isa_status_cell #(.MODE(mode_of(i))) u_cell (
                .clk (clk),
                .rst (rst),
                .ctl (ctl),
                .q   (status[i])
            );
        end
    endgenerate

    assign status[STAT_W-1] = 1'b0;
endmodule

// File: rtl/isa_alert_gen.sv
module isa_alert_gen
    import isa_pkg::*;
(
    input  logic [ALERT_SRC-1:0] src,
    input  logic [ALERT_SRC-1:0] en,
    output logic                 alert_n
);
    assign alert_n = ~(|(src & en));
endmodule

// File: rtl/intr_summary_status.sv
module intr_summary_status
    import isa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_stb,
    input  logic [SRC_W-1:0]     ev,
    input  logic [SRC_W-1:0]     grp_clr,
    input  logic [ALERT_SRC-1:0] alert_en,
    output logic [STAT_W-1:0]    rd_data,
    output logic                 alert_n
);
    logic [STAT_W-1:0] status;

    isa_status_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (rd_stb),
        .ev      (ev),
        .grp_clr (grp_clr),
        .status  (status)
    );

    isa_alert_gen u_alert (
        .src     (status[ALERT_SRC-1:0]),
        .en      (alert_en),
        .alert_n (alert_n)
    );

    // Read data is the held status, so a read sees the value before its clear.
    assign rd_data = status;
endmodule

// File: rtl/isa_chk.sv
module isa_chk
    import isa_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_stb,
    input logic [SRC_W-1:0]     ev,
    input logic [SRC_W-1:0]     grp_clr,
    input logic [ALERT_SRC-1:0] alert_en,
    input logic [STAT_W-1:0]    rd_data,
    input logic                 alert_n
);
    localparam logic [SRC_W-1:0] GROUP_BITS = 7'h2F;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (rd_data == 8'h00 && alert_n));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst) rd_data[7] == 1'b0);

    // R3
    event_sets_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rd_data[SRC_W-1:0] & $past(ev)) == $past(ev)));

    // R4
    read_clears_ovt_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !ev[BIT_OVT]) |=> !rd_data[BIT_OVT]);

    // R4
    read_clears_gpi_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !ev[BIT_GPI]) |=> !rd_data[BIT_GPI]);

    // R5
    group_survives_read_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(rd_data[SRC_W-1:0]) & GROUP_BITS & ~$past(grp_clr))
                   & ~rd_data[SRC_W-1:0]) == '0));

    // R8
    alert_match_chk: assert property (@(posedge clk) disable iff (rst)
        alert_n == !(|(rd_data[ALERT_SRC-1:0] & alert_en)));

    // R9
    ovt_no_alert_chk: assert property (@(posedge clk) disable iff (rst)
        ($changed(rd_data[BIT_OVT]) && $stable(rd_data[ALERT_SRC-1:0]) && $stable(alert_en))
        |-> $stable(alert_n));
endmodule

bind intr_summary_status isa_chk u_chk (.*);

// File: tb/intr_summary_status_tb.sv
`timescale 1ns/1ps
module intr_summary_status_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       rd_stb;
    logic [6:0] ev;
    logic [6:0] grp_clr;
    logic [5:0] alert_en;
    logic [7:0] rd_data;
    logic       alert_n;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    intr_summary_status u_dut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .ev(ev), .grp_clr(grp_clr),
        .alert_en(alert_en), .rd_data(rd_data), .alert_n(alert_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_stb = 1'b0; ev = '0; grp_clr = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Apply one cycle of inputs, then return them to idle at the next negedge.
    task automatic cyc(input logic rd, input logic [6:0] e, input logic [6:0] c);
        rd_stb = rd; ev = e; grp_clr = c;
        @(negedge clk);
        rd_stb = 1'b0; ev = '0; grp_clr = '0;
    endtask

    function automatic logic exp_alert(input logic [7:0] s, input logic [5:0] en);
        return !(|(s[5:0] & en));
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rd_stb = 1'b0; ev = '0; grp_clr = '0; alert_en = '1;
        do_reset();
        // R1 reset state
        chk("R1 reset rd_data", rd_data, 8'h00);
        chk("R1 reset alert_n", {7'b0, alert_n}, 8'h01);

        // Sweep every event pattern against every enable pattern.
        for (int p = 0; p < 128; p++) begin
            do_reset();
            @(negedge clk);
            cyc(1'b0, p[6:0], '0);
            // R3 / R2 event pattern captured, bit 7 zero
            chk("R3 event set", rd_data, {1'b0, p[6:0]});
            for (int m = 0; m < 64; m++) begin
                alert_en = m[5:0];
                #1;
                // R8 / R9 alert versus enables, bit 6 ignored
                chk("R8 alert", {7'b0, alert_n}, {7'b0, exp_alert({1'b0, p[6:0]}, m[5:0])});
            end
            alert_en = '1;
            cyc(1'b1, '0, '0);
            // R4 / R5 read drops bits 6 and 4 only
            chk("R4 read clear", rd_data, {1'b0, p[6:0]} & 8'h2F);
            cyc(1'b0, '0, 7'h7F);
            // R5 group clear empties the rest
            chk("R5 group clear", rd_data, 8'h00);
        end

        // R9 over-temperature alone with all enables
        do_reset();
        alert_en = '1;
        cyc(1'b0, 7'h40, '0);
        chk("R9 ovt alone alert_n", {7'b0, alert_n}, 8'h01);

        // R6 group clear ignored on bits 6 and 4
        cyc(1'b0, 7'h10, '0);
        cyc(1'b0, '0, 7'h7F);
        chk("R6 grp_clr ignored", rd_data, 8'h50);

        // R7 read returns pre-clear value, clear follows
        rd_stb = 1'b1;
        #1;
        chk("R7 pre-clear value", rd_data, 8'h50);
        @(negedge clk);
        rd_stb = 1'b0;
        chk("R7 after read", rd_data, 8'h00);

        // R4 event during read wins
        cyc(1'b0, 7'h50, '0);
        cyc(1'b1, 7'h40, '0);
        chk("R4 event beats read", rd_data, 8'h40);

        // R5 event during group clear wins, and read leaves it
        cyc(1'b0, 7'h08, '0);
        cyc(1'b0, 7'h08, 7'h08);
        chk("R5 event beats group clear", rd_data, 8'h48);
        cyc(1'b1, '0, '0);
        chk("R5 read ignored on fan", rd_data, 8'h08);
        chk("R8 fan alert", {7'b0, alert_n}, 8'h00);

        // R3 sticky across idle cycles
        repeat (5) @(negedge clk);
        chk("R3 sticky", rd_data, 8'h08);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule